// File: doc/BRIEF.md
# Serial SAR ADC Conversion Sequencer

This block is the host side of a three-wire link to an 8-bit successive-approximation converter. A request names the channel and the input mode. The block then lowers the active-low chip select and produces a serial clock from the system clock through a programmable half-period divider. It shifts out a start bit and a two-bit address, throws away the settling bit, and collects the result. The converter returns the result twice. The first stream is MSB-first. The second stream is LSB-first and supplies only the bits above bit 0, because bit 0 sits at the turnaround and is shared by both streams. The block rebuilds the value from each stream, compares the two, and reports a mismatch flag next to the 8-bit result.

A second mode suits a converter with one fixed input. In this mode no address is sent, only the MSB-first stream is read, and the frame ends after the eighth data bit. When the host-out line is tied to the converter's data line on a single wire, an output-enable shows when the host must drive it.

Top module: `sar_link_host`

## Requirements
- R1: After reset, adc_sel_no is 1, sck_o is 0, sdo_o and sdo_oe_o are 0, ready_o is 1, busy_o is 0, valid_o is 0, result_o is 0 and mismatch_o is 0.
- R2: A request is accepted on a clock edge where req_i and ready_o are both 1. After that edge, adc_sel_no is 0, busy_o is 1 and ready_o is 0. A req_i seen while ready_o is 0 has no effect: the running frame keeps its address and no extra frame follows.
- R3: Each low and high phase of sck_o lasts H system cycles. H is half_period_i, or 1 when that input is 0, and it is captured when the request is accepted. The first rising edge of sck_o comes H cycles after adc_sel_no falls.
- R4: sdo_o changes only while sck_o is low. In address mode it carries 1, then addr_single_i, then addr_odd_i, one value in each of the first three sck_o periods, and it is 0 after that.
- R5: Address encoding, as (addr_single_i, addr_odd_i): (1,0) selects single-ended input 0; (1,1) selects single-ended input 1; (0,0) selects differential with input 0 positive; (0,1) selects differential with input 1 positive. The bits are sent unchanged.
- R6: In address mode a frame has 19 sck_o periods. sdi_i is sampled at each rising edge. The 4th sample is discarded. Samples 5 to 12 are D7 down to D0, and samples 13 to 19 are D1 up to D7.
- R7: mismatch_o is 1 after an address-mode frame exactly when some bit D1..D7 from the LSB-first stream differs from the same bit of the MSB-first stream. result_o is always the MSB-first value.
- R8: When fixed_chan_i is 1 at acceptance, sdo_o and sdo_oe_o stay 0. The frame has 9 periods: the first sample is discarded and samples 2 to 9 are D7 down to D0. mismatch_o is then 0.
- R9: adc_sel_no rises on the same edge as the last falling edge of sck_o. valid_o is 1 for exactly that one cycle, and result_o and mismatch_o take their new values then. They hold those values until the next frame completes.
- R10: After a frame, adc_sel_no stays 1 for H cycles with ready_o 0. ready_o then returns to 1.
- R11: sdo_oe_o is 1 from acceptance until the falling sck_o edge after the third rising edge of an address-mode frame, and 0 otherwise. It is never 1 while adc_sel_no is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Conversion request |
| addr_single_i | input | 1 | Address bit: 1 single-ended, 0 differential |
| addr_odd_i | input | 1 | Address bit: input 1 / polarity select |
| fixed_chan_i | input | 1 | 1 = no address, MSB-first stream only |
| half_period_i | input | DIV_W | sck_o half period in system cycles (0 acts as 1) |
| ready_o | output | 1 | Idle, a request may be accepted |
| busy_o | output | 1 | Frame in progress |
| adc_sel_no | output | 1 | Converter chip select, active low |
| sck_o | output | 1 | Serial clock to converter |
| sdo_o | output | 1 | Host-to-converter data |
| sdo_oe_o | output | 1 | Host drives sdo_o on a shared wire |
| sdi_i | input | 1 | Converter-to-host data |
| result_o | output | DATA_W | Conversion result |
| mismatch_o | output | 1 | The two result streams disagree |
| valid_o | output | 1 | One-cycle pulse when result_o updates |

## Verification
Several events fall on the same system edge: the final falling sck_o edge, the rise of adc_sel_no, the load of the result registers and the valid_o pulse. With H = 1, the divider reload and the start of the gap also land on that edge. The bench drives frames with half periods of 0, 1 and larger values. It then judges that the valid pulse is a single cycle, that the gap lasts exactly H cycles with chip select high, and that the edge count matches the mode. A second collision is a request that arrives during a running frame while the divider input also changes. The bench checks that the captured address, the phase lengths and the number of frames stay those of the original request.

// File: rtl/sar_link_pkg.sv
package sar_link_pkg;
  localparam int ADDR_LEN = 3;  // start bit + two address bits

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_GAP} link_st_e;
  typedef enum logic [1:0] {SLOT_ADDR, SLOT_NULL, SLOT_MSB, SLOT_LSB} slot_e;
endpackage

// File: rtl/sar_link_clkdiv.sv
module sar_link_clkdiv #(
  parameter int DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic [DIV_W-1:0] half_o,
  output logic             tick_o
);
  localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

  logic [DIV_W-1:0] half_q, cnt_q, half_eff;

  assign half_eff = (half_i == '0) ? ONE : half_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= ONE;
      cnt_q  <= '0;
    end else if (start_i) begin
      half_q <= half_eff;
      cnt_q  <= half_eff - ONE;
    end else if (run_i) begin
      if (cnt_q == '0) cnt_q <= half_q - ONE;
      else             cnt_q <= cnt_q - ONE;
    end
  end

  assign tick_o = run_i && !start_i && (cnt_q == '0);
  assign half_o = half_q;
endmodule

// File: rtl/sar_link_seq.sv
module sar_link_seq
  import sar_link_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PER_W  = 5
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  req_i,
  input  logic  addr_single_i,
  input  logic  addr_odd_i,
  input  logic  fixed_chan_i,
  input  logic  tick_i,
  output logic  start_o,
  output logic  run_o,
  output logic  ready_o,
  output logic  busy_o,
  output logic  sel_no,
  output logic  sck_o,
  output logic  sdo_o,
  output logic  sdo_oe_o,
  output logic  sample_o,
  output slot_e slot_o,
  output logic  done_o,
  output logic  fixed_o
);
  localparam int FULL_PER  = ADDR_LEN + 1 + 2*DATA_W - 1;
  localparam int FIXED_PER = 1 + DATA_W;
  localparam logic [PER_W-1:0] FULL_LAST  = PER_W'(FULL_PER - 1);
  localparam logic [PER_W-1:0] FIXED_LAST = PER_W'(FIXED_PER - 1);
  localparam logic [PER_W-1:0] NULL_IDX   = PER_W'(ADDR_LEN);
  localparam logic [PER_W-1:0] LSB_LO     = PER_W'(ADDR_LEN + 1 + DATA_W);
  localparam logic [PER_W-1:0] ONE        = PER_W'(1);
  localparam logic [PER_W-1:0] TWO        = PER_W'(2);

  link_st_e         st_q;
  logic [PER_W-1:0] per_q, nxt_per, last_per;
  logic             sck_q, sel_nq, sdo_q, oe_q;
  logic             sgl_q, odd_q, fixed_q;
  logic             nxt_sdo, nxt_oe, at_last;

  assign start_o  = (st_q == ST_IDLE) && req_i;
  assign run_o    = (st_q != ST_IDLE);
  assign nxt_per  = per_q + ONE;
  assign last_per = fixed_q ? FIXED_LAST : FULL_LAST;
  assign at_last  = (per_q == last_per);

  // bit driven during the next period, set up on the falling edge
  always_comb begin
    nxt_sdo = 1'b0;
    nxt_oe  = 1'b0;
    if (!fixed_q && nxt_per < NULL_IDX) begin
      nxt_oe  = 1'b1;
      nxt_sdo = (nxt_per == ONE) ? sgl_q : (nxt_per == TWO) ? odd_q : 1'b0;
    end
  end

  always_comb begin
    if (fixed_q)                slot_o = (per_q == '0) ? SLOT_NULL : SLOT_MSB;
    else if (per_q < NULL_IDX)  slot_o = SLOT_ADDR;
    else if (per_q == NULL_IDX) slot_o = SLOT_NULL;
    else if (per_q < LSB_LO)    slot_o = SLOT_MSB;
    else                        slot_o = SLOT_LSB;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      per_q   <= '0;
      sck_q   <= 1'b0;
      sel_nq  <= 1'b1;
      sdo_q   <= 1'b0;
      oe_q    <= 1'b0;
      sgl_q   <= 1'b0;
      odd_q   <= 1'b0;
      fixed_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          st_q    <= ST_RUN;
          per_q   <= '0;
          sck_q   <= 1'b0;
          sel_nq  <= 1'b0;
          sdo_q   <= !fixed_chan_i;
          oe_q    <= !fixed_chan_i;
          sgl_q   <= addr_single_i;
          odd_q   <= addr_odd_i;
          fixed_q <= fixed_chan_i;
        end
        ST_RUN: if (tick_i) begin
          if (!sck_q) begin
            sck_q <= 1'b1;
          end else begin
            sck_q <= 1'b0;
            if (at_last) begin
              st_q   <= ST_GAP;
              sel_nq <= 1'b1;
              sdo_q  <= 1'b0;
              oe_q   <= 1'b0;
            end else begin
              per_q <= nxt_per;
              sdo_q <= nxt_sdo;
              oe_q  <= nxt_oe;
            end
          end
        end
        ST_GAP: if (tick_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sample_o = (st_q == ST_RUN) && tick_i && !sck_q;
  assign done_o   = (st_q == ST_RUN) && tick_i && sck_q && at_last;
  assign ready_o  = (st_q == ST_IDLE);
  assign busy_o   = (st_q == ST_RUN);
  assign sel_no   = sel_nq;
  assign sck_o    = sck_q;
  assign sdo_o    = sdo_q;
  assign sdo_oe_o = oe_q;
  assign fixed_o  = fixed_q;
endmodule

// File: rtl/sar_link_capture.sv
module sar_link_capture
  import sar_link_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sample_i,
  input  slot_e             slot_i,
  input  logic              sdi_i,
  input  logic              done_i,
  input  logic              fixed_i,
  output logic [DATA_W-1:0] result_o,
  output logic              mismatch_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] msb_q, lsb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msb_q <= '0;
      lsb_q <= '0;
    end else if (start_i) begin
      msb_q <= '0;
      lsb_q <= '0;
    end else if (sample_i) begin
      if (slot_i == SLOT_MSB) msb_q <= {msb_q[DATA_W-2:0], sdi_i};
      if (slot_i == SLOT_LSB) lsb_q <= {sdi_i, lsb_q[DATA_W-1:1]};
    end
  end

  // bit 0 is the turnaround bit shared by both streams
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o   <= '0;
      mismatch_o <= 1'b0;
      valid_o    <= 1'b0;
    end else begin
      valid_o <= done_i;
      if (done_i) begin
        result_o   <= msb_q;
        mismatch_o <= !fixed_i && (lsb_q[DATA_W-1:1] != msb_q[DATA_W-1:1]);
      end
    end
  end
endmodule

// File: rtl/sar_link_host.sv
module sar_link_host
  import sar_link_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              addr_single_i,
  input  logic              addr_odd_i,
  input  logic              fixed_chan_i,
  input  logic [DIV_W-1:0]  half_period_i,
  output logic              ready_o,
  output logic              busy_o,
  output logic              adc_sel_no,
  output logic              sck_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic              sdi_i,
  output logic [DATA_W-1:0] result_o,
  output logic              mismatch_o,
  output logic              valid_o
);
  localparam int PER_W = $clog2(2*DATA_W + 4);

  logic             start, run, tick, sample, done, fixed_q;
  logic [DIV_W-1:0] half_q;
  slot_e            slot;

  sar_link_clkdiv #(.DIV_W(DIV_W)) i_clkdiv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .run_i   (run),
    .half_i  (half_period_i),
    .half_o  (half_q),
    .tick_o  (tick)
  );

  sar_link_seq #(.DATA_W(DATA_W), .PER_W(PER_W)) i_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (req_i),
    .addr_single_i (addr_single_i),
    .addr_odd_i    (addr_odd_i),
    .fixed_chan_i  (fixed_chan_i),
    .tick_i        (tick),
    .start_o       (start),
    .run_o         (run),
    .ready_o       (ready_o),
    .busy_o        (busy_o),
    .sel_no        (adc_sel_no),
    .sck_o         (sck_o),
    .sdo_o         (sdo_o),
    .sdo_oe_o      (sdo_oe_o),
    .sample_o      (sample),
    .slot_o        (slot),
    .done_o        (done),
    .fixed_o       (fixed_q)
  );

  sar_link_capture #(.DATA_W(DATA_W)) i_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .sample_i   (sample),
    .slot_i     (slot),
    .sdi_i      (sdi_i),
    .done_i     (done),
    .fixed_i    (fixed_q),
    .result_o   (result_o),
    .mismatch_o (mismatch_o),
    .valid_o    (valid_o)
  );
endmodule

// File: rtl/sar_link_host_chk.sv
module sar_link_host_chk #(
  parameter int DIV_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             ready_o,
  input logic             busy_o,
  input logic             adc_sel_no,
  input logic             sck_o,
  input logic             sdo_o,
  input logic             sdo_oe_o,
  input logic             valid_o,
  input logic             mismatch_o,
  input logic             fixed_q_i,
  input logic [DIV_W-1:0] half_q_i
);
  logic           sck_d, sel_d;
  logic [DIV_W:0] ph_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d  <= 1'b0;
      sel_d  <= 1'b1;
      ph_cnt <= '0;
    end else begin
      sck_d <= sck_o;
      sel_d <= adc_sel_no;
      if ((sck_o != sck_d) || (sel_d && !adc_sel_no)) ph_cnt <= 1;
      else if (ph_cnt != '1) ph_cnt <= ph_cnt + 1'b1;
    end
  end

  // R2
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && req_i |=> !adc_sel_no && busy_o && !ready_o);

  // R10
  idle_sel_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> adc_sel_no && !sck_o);

  // R2
  busy_sel_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !adc_sel_no);

  // R3
  phase_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_sel_no && (sck_o != sck_d) |-> ph_cnt == {1'b0, half_q_i});

  // R4
  sdo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o && $past(sck_o) |-> $stable(sdo_o));

  // R4
  sdo_addr_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_o |-> sdo_oe_o);

  // R11
  oe_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_o |-> !adc_sel_no);

  // R9
  valid_at_sel_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $rose(adc_sel_no) && !sck_o);

  // R9
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R8
  fixed_no_mismatch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && fixed_q_i |-> !mismatch_o);
endmodule

bind sar_link_host sar_link_host_chk #(.DIV_W(DIV_W)) i_sar_link_host_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .ready_o    (ready_o),
  .busy_o     (busy_o),
  .adc_sel_no (adc_sel_no),
  .sck_o      (sck_o),
  .sdo_o      (sdo_o),
  .sdo_oe_o   (sdo_oe_o),
  .valid_o    (valid_o),
  .mismatch_o (mismatch_o),
  .fixed_q_i  (fixed_q),
  .half_q_i   (half_q)
);

// File: tb/test_sar_link_host.sv
module test_sar_link_host;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 12;
  localparam int NVEC   = 9;
  // {fixed, single, odd, half[4:0], data[7:0], lsb-stream corrupt mask[7:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    24'h43A500, 24'h623C00, 24'h01FF00, 24'h240000, 24'h428110,
    24'h835A00, 24'h80C3FF, 24'h207E80, 24'h650102
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, a_sgl = 1'b0, a_odd = 1'b0, fixed = 1'b0;
  logic [DIV_W-1:0] half = '0;
  logic ready, busy, sel_n, sck, sdo, sdo_oe, valid, mismatch;
  logic [DATA_W-1:0] result;

  int checks = 0, fails = 0;

  // device model state (driven by the stimulus tasks)
  logic [7:0] dev_data = '0, dev_corrupt = '0;
  logic       dev_fixed = 1'b0;
  int         exp_half = 1;

  always #10 clk = ~clk;

  sar_link_host #(.DATA_W(DATA_W), .DIV_W(DIV_W)) i_sar_link_host (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_single_i(a_sgl),
    .addr_odd_i(a_odd), .fixed_chan_i(fixed), .half_period_i(half),
    .ready_o(ready), .busy_o(busy), .adc_sel_no(sel_n), .sck_o(sck),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .sdi_i(dev_do), .result_o(result),
    .mismatch_o(mismatch), .valid_o(valid)
  );

  // converter model
  logic       dev_do = 1'b0;
  int         rises = 0, sel_falls = 0, seen_falls = 0;
  logic [2:0] addr_seen = '0;
  int         stray_ones = 0, oe_err = 0;

  function automatic logic dev_bit(int n);
    if (dev_fixed) return (n >= 1 && n <= 8) ? dev_data[8-n] : 1'b0;
    if (n >= 4 && n <= 11) return dev_data[11-n];
    if (n >= 12 && n <= 18) return dev_data[n-11] ^ dev_corrupt[n-11];
    return 1'b0;
  endfunction

  always @(negedge sel_n) sel_falls++;

  always @(posedge sck) begin
    if (!sel_n) begin
      if (sel_falls != seen_falls) begin
        rises = 0;
        seen_falls = sel_falls;
      end
      if (!dev_fixed && rises < 3) addr_seen[2-rises] = sdo;
      else if (sdo) stray_ones++;
      if (sdo_oe != (!dev_fixed && rises < 3)) oe_err++;
      rises++;
    end
  end

  always @(negedge sck) if (!sel_n) dev_do = dev_bit(rises);

  // phase length and sdo stability monitor
  int   ph_err = 0, hold_err = 0, mon_len = 0;
  logic mon_prev_sel = 1'b1, mon_sck = 1'b0, mon_sck_d = 1'b0, mon_sdo = 1'b0;
  always @(negedge clk) begin
    if (!sel_n) begin
      if (mon_prev_sel) begin mon_len = 1; mon_sck = sck; end
      else if (sck == mon_sck) mon_len++;
      else begin
        if (mon_len != exp_half) ph_err++;
        mon_len = 1;
        mon_sck = sck;
      end
      if (sck && mon_sck_d && sdo != mon_sdo) hold_err++;
    end
    mon_prev_sel = sel_n;
    mon_sck_d = sck;
    mon_sdo = sdo;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic setup(input logic f, input logic s, input logic o, input int h,
                       input logic [7:0] d, input logic [7:0] c);
    dev_fixed = f; dev_data = d; dev_corrupt = c;
    exp_half = (h == 0) ? 1 : h;
    while (!ready) @(negedge clk);
    fixed = f; a_sgl = s; a_odd = o; half = DIV_W'(h);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk(!sel_n && busy && !ready, "R2 accept", {sel_n, busy, ready}, 3'b010);
  endtask

  task automatic finish_txn(output bit got);
    int n;
    got = 1'b0;
    for (int i = 0; i < 5000 && !got; i++) begin
      @(negedge clk);
      if (valid) got = 1'b1;
    end
    chk(got, "R9 valid seen", got, 1);
    n = 0;
    while (got && !ready && n < 5000) begin
      @(negedge clk);
      n++;
      if (!ready) chk(sel_n && !valid, "R10/R9 gap", {sel_n, valid}, 2'b10);
    end
    chk(n == exp_half, "R10 gap length", n, exp_half);
  endtask

  task automatic run_vec(input logic [23:0] v);
    int ph0, hold0, oe0, stray0, exp_rises;
    bit got;
    logic [7:0] res_seen;
    logic mm_seen, exp_mm;
    ph0 = ph_err; hold0 = hold_err; oe0 = oe_err; stray0 = stray_ones;
    setup(v[23], v[22], v[21], int'(v[20:16]), v[15:8], v[7:0]);
    finish_txn(got);
    res_seen = result; mm_seen = mismatch;
    exp_rises = v[23] ? 9 : 19;
    exp_mm = !v[23] && (v[7:1] != 7'd0);
    chk(res_seen == v[15:8], v[23] ? "R8 fixed result" : "R6 result", res_seen, v[15:8]);
    chk(mm_seen == exp_mm, v[23] ? "R8 no mismatch" : "R7 mismatch", mm_seen, exp_mm);
    chk(rises == exp_rises, v[23] ? "R8 edge count" : "R6 edge count", rises, exp_rises);
    if (!v[23]) chk(addr_seen == {1'b1, v[22], v[21]}, "R5 address bits", addr_seen, {1'b1, v[22], v[21]});
    chk(stray_ones == stray0, v[23] ? "R8 sdo idle" : "R4 sdo low after addr", stray_ones - stray0, 0);
    chk(oe_err == oe0, "R11 output enable", oe_err - oe0, 0);
    chk(ph_err == ph0, "R3 phase length", ph_err - ph0, 0);
    chk(hold_err == hold0, "R4 sdo stable while high", hold_err - hold0, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks + 1, fails + 1);
    $finish;
  end

  initial begin : main
    bit got;
    int ph0, falls0;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sel_n && !sck && !sdo && !sdo_oe, "R1 link idle", {sel_n, sck, sdo, sdo_oe}, 4'b1000);
    chk(ready && !busy && !valid, "R1 handshake idle", {ready, busy, valid}, 3'b100);
    chk(result == 8'h00 && !mismatch, "R1 result cleared", {mismatch, result}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NVEC; k++) run_vec(VEC[k]);

    // R2/R3: request and divider change during a running frame are ignored
    ph0 = ph_err;
    falls0 = sel_falls;
    setup(1'b0, 1'b1, 1'b1, 3, 8'h96, 8'h00);
    half = DIV_W'(7);
    repeat (10) @(negedge clk);
    a_sgl = 1'b0; a_odd = 1'b0; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    finish_txn(got);
    chk(addr_seen == 3'b111, "R2 address kept", addr_seen, 3'b111);
    chk(ph_err == ph0, "R3 divider latched", ph_err - ph0, 0);
    chk(result == 8'h96, "R2 result of first request", result, 8'h96);
    held = result;
    repeat (40) @(negedge clk);
    chk(sel_falls == falls0 + 1 && sel_n, "R2 no extra frame", sel_falls - falls0, 1);
    chk(result == held && !mismatch, "R9 result held", result, held);

    // R9/R10 back-to-back with H = 1
    run_vec(24'h40AA00);
    run_vec(24'h805500);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule